// File: doc/BRIEF.md
# Rotating Register File

This block is a register file for software-pipelined loops in which every logical register behaves as an array of elements. Each access gives a logical base and a small signed element offset. The block turns these into a physical entry: (base + offset + rotation base) modulo the file size. The rotation base is held internally. The file size is a power of two that is fixed when the block is built.

A loop writes each new value at element -1 of its register. At the end of every loop iteration the loop asserts `rotate_i`, which lowers the rotation base by one. The value written as element -1 is then read as element 0, and older values move to elements 1, 2 and so on. No data is copied. Only a bounded, contiguous window of elements of each register is live at any time, and that window occupies consecutive physical entries.

The block has two combinational read ports and one write port that updates on the clock edge. A separate clear input returns the rotation base to zero between loops without touching the stored data.

Top module: `rotating_reg_file`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the rotation base is zero and every entry reads as zero.
- R2: A write with `we_i` high stores `wr_data_i` at physical entry (wr_base_i + wr_off_i + rotation base) mod NUM_REGS. From the next cycle, a read that resolves to the same entry returns that data. Offsets are two's complement.
- R3: Each cycle with `rotate_i` high and `rrb_clr_i` low lowers the rotation base by one, modulo NUM_REGS. A value written at element -1 then reads at element 0 one rotation later, and at element 1 two rotations later.
- R4: Physical indices wrap modulo NUM_REGS. After NUM_REGS rotations the mapping from (base, offset) to entry is the same as it was before them.
- R5: A write in the same cycle as a rotate or a clear uses the rotation base from before that cycle's update.
- R6: A read that resolves to the entry being written in the same cycle returns `wr_data_i` in that cycle (write-first bypass).
- R7: `rrb_clr_i` sets the rotation base to zero on the next edge and leaves stored data unchanged. It takes priority over `rotate_i`.
- R8: With `we_i` low, `wr_data_i`, `wr_base_i` and `wr_off_i` have no effect on any stored entry.
- R9: The two read ports resolve their addresses independently. Each accepts negative and positive offsets over the full OFF_W range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rotate_i | input | 1 | End-of-iteration remap; lowers the rotation base |
| rrb_clr_i | input | 1 | Return rotation base to zero |
| we_i | input | 1 | Write enable |
| wr_base_i | input | $clog2(NUM_REGS) | Write logical base |
| wr_off_i | input | OFF_W | Write element offset, signed |
| wr_data_i | input | DATA_W | Write data |
| rd0_base_i | input | $clog2(NUM_REGS) | Read port 0 logical base |
| rd0_off_i | input | OFF_W | Read port 0 element offset, signed |
| rd0_data_o | output | DATA_W | Read port 0 data |
| rd1_base_i | input | $clog2(NUM_REGS) | Read port 1 logical base |
| rd1_off_i | input | OFF_W | Read port 1 element offset, signed |
| rd1_data_o | output | DATA_W | Read port 1 data |

## Verification
Read data has no latency. It follows the current address inputs and the current write inputs in the same cycle. Writes, rotations and clears become visible only on the read ports from the cycle after their clock edge. The bench drives all inputs just after a falling edge and compares both read ports against a behavioural model shortly afterwards, before the rising edge. It updates the model's storage and rotation base only after that rising edge. As a result, same-cycle bypass and next-cycle visibility are each checked in the cycle where they are due.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  typedef enum logic [1:0] {
    RRB_HOLD = 2'd0,
    RRB_DEC  = 2'd1,
    RRB_ZERO = 2'd2
  } rrb_op_e;
endpackage

// File: rtl/rrf_base_ctr.sv
module rrf_base_ctr #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rotate_i,
  input  logic             clear_i,
  output logic [IDX_W-1:0] rrb_o
);
  import rrf_pkg::*;

  rrb_op_e          op;
  logic [IDX_W-1:0] rrb_q, rrb_d;

  // clear wins over rotate
  always_comb begin
    if (clear_i)       op = RRB_ZERO;
    else if (rotate_i) op = RRB_DEC;
    else               op = RRB_HOLD;
  end

  always_comb begin
    unique case (op)
      RRB_DEC:  rrb_d = rrb_q - IDX_W'(1);
      RRB_ZERO: rrb_d = '0;
      default:  rrb_d = rrb_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rrb_q <= '0;
    else         rrb_q <= rrb_d;
  end

  assign rrb_o = rrb_q;
endmodule

// File: rtl/rrf_addr_map.sv
module rrf_addr_map #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned OFF_W = 4
) (
  input  logic              [IDX_W-1:0] base_i,
  input  logic signed       [OFF_W-1:0] off_i,
  input  logic              [IDX_W-1:0] rrb_i,
  output logic              [IDX_W-1:0] idx_o
);
  localparam int unsigned SUM_W = (IDX_W > OFF_W) ? IDX_W : OFF_W;

  logic [SUM_W-1:0] off_ext;
  logic [SUM_W-1:0] sum;

  // sign-extend, then let the add wrap; low bits give mod 2^IDX_W
  assign off_ext = SUM_W'(off_i);
  assign sum     = SUM_W'(base_i) + off_ext + SUM_W'(rrb_i);
  assign idx_o   = sum[IDX_W-1:0];
endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_RD = 2,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i  [NUM_RD],
  output logic [DATA_W-1:0] rdata_o [NUM_RD]
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    logic hit;
    assign hit        = we_i && (widx_i == ridx_i[g]);
    assign rdata_o[g] = hit ? wdata_i : mem_q[ridx_i[g]];
  end
endmodule

// File: rtl/rotating_reg_file.sv
module rotating_reg_file #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned OFF_W    = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rotate_i,
  input  logic                    rrb_clr_i,
  input  logic                    we_i,
  input  logic        [IDX_W-1:0] wr_base_i,
  input  logic signed [OFF_W-1:0] wr_off_i,
  input  logic       [DATA_W-1:0] wr_data_i,
  input  logic        [IDX_W-1:0] rd0_base_i,
  input  logic signed [OFF_W-1:0] rd0_off_i,
  output logic       [DATA_W-1:0] rd0_data_o,
  input  logic        [IDX_W-1:0] rd1_base_i,
  input  logic signed [OFF_W-1:0] rd1_off_i,
  output logic       [DATA_W-1:0] rd1_data_o
);
  localparam int unsigned NUM_RD = 2;

  logic              [IDX_W-1:0]  rrb_q;
  logic              [IDX_W-1:0]  widx;
  logic              [IDX_W-1:0]  rd_base [NUM_RD];
  logic signed       [OFF_W-1:0]  rd_off  [NUM_RD];
  logic              [IDX_W-1:0]  ridx    [NUM_RD];
  logic              [DATA_W-1:0] rdata   [NUM_RD];

  assign rd_base[0] = rd0_base_i;
  assign rd_off[0]  = rd0_off_i;
  assign rd_base[1] = rd1_base_i;
  assign rd_off[1]  = rd1_off_i;

  rrf_base_ctr #(.IDX_W(IDX_W)) u_base_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rotate_i (rotate_i),
    .clear_i  (rrb_clr_i),
    .rrb_o    (rrb_q)
  );

  // write uses the pre-update base
  rrf_addr_map #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_wr_map (
    .base_i (wr_base_i),
    .off_i  (wr_off_i),
    .rrb_i  (rrb_q),
    .idx_o  (widx)
  );

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd_map
    rrf_addr_map #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_rd_map (
      .base_i (rd_base[g]),
      .off_i  (rd_off[g]),
      .rrb_i  (rrb_q),
      .idx_o  (ridx[g])
    );
  end

  rrf_storage #(.DEPTH(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(NUM_RD)) u_storage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .widx_i  (widx),
    .wdata_i (wr_data_i),
    .ridx_i  (ridx),
    .rdata_o (rdata)
  );

  assign rd0_data_o = rdata[0];
  assign rd1_data_o = rdata[1];
endmodule

// File: rtl/rrf_chk.sv
module rrf_chk #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned OFF_W    = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    rotate_i,
  input logic                    rrb_clr_i,
  input logic                    we_i,
  input logic        [IDX_W-1:0] wr_base_i,
  input logic signed [OFF_W-1:0] wr_off_i,
  input logic       [DATA_W-1:0] wr_data_i,
  input logic        [IDX_W-1:0] rd0_base_i,
  input logic signed [OFF_W-1:0] rd0_off_i,
  input logic       [DATA_W-1:0] rd0_data_o,
  input logic        [IDX_W-1:0] rd1_base_i,
  input logic signed [OFF_W-1:0] rd1_off_i,
  input logic       [DATA_W-1:0] rd1_data_o,
  input logic        [IDX_W-1:0] rrb
);
  function automatic int map_idx(int b, int o, int r);
    return (((b + o + r) % int'(NUM_REGS)) + int'(NUM_REGS)) % int'(NUM_REGS);
  endfunction

  int w_i, r0_i, r1_i;
  assign w_i  = map_idx(int'(wr_base_i), int'(wr_off_i), int'(rrb));
  assign r0_i = map_idx(int'(rd0_base_i), int'(rd0_off_i), int'(rrb));
  assign r1_i = map_idx(int'(rd1_base_i), int'(rd1_off_i), int'(rrb));

  // R3
  rrb_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rotate_i && !rrb_clr_i |=> rrb == IDX_W'($past(rrb) - IDX_W'(1)));

  // R3
  rrb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rotate_i && !rrb_clr_i |=> $stable(rrb));

  // R7
  rrb_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rrb_clr_i |=> rrb == '0);

  // R6
  bypass0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (w_i == r0_i) |-> rd0_data_o == wr_data_i);

  // R6
  bypass1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (w_i == r1_i) |-> rd1_data_o == wr_data_i);

  // R5
  raw_rd0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i) && !we_i && (r0_i == $past(w_i)) |-> rd0_data_o == $past(wr_data_i));
endmodule

bind rotating_reg_file rrf_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .OFF_W    (OFF_W)
) u_rrf_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rotate_i   (rotate_i),
  .rrb_clr_i  (rrb_clr_i),
  .we_i       (we_i),
  .wr_base_i  (wr_base_i),
  .wr_off_i   (wr_off_i),
  .wr_data_i  (wr_data_i),
  .rd0_base_i (rd0_base_i),
  .rd0_off_i  (rd0_off_i),
  .rd0_data_o (rd0_data_o),
  .rd1_base_i (rd1_base_i),
  .rd1_off_i  (rd1_off_i),
  .rd1_data_o (rd1_data_o),
  .rrb        (rrb_q)
);

// File: tb/rotating_reg_file_tb_top.sv
module rotating_reg_file_tb_top;
  localparam int N     = 32;
  localparam int DW    = 32;
  localparam int OW    = 4;
  localparam int IW    = $clog2(N);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rotate_i = 1'b0, rrb_clr_i = 1'b0, we_i = 1'b0;
  logic [IW-1:0] wr_base_i = '0, rd0_base_i = '0, rd1_base_i = '0;
  logic signed [OW-1:0] wr_off_i = '0, rd0_off_i = '0, rd1_off_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd0_data_o, rd1_data_o;

  always #5 clk_i = ~clk_i;

  rotating_reg_file #(.NUM_REGS(N), .DATA_W(DW), .OFF_W(OW)) dut_i (.*);

  int checks = 0, failures = 0;
  bit done = 0;
  logic [DW-1:0] m_mem [N];
  int m_rrb = 0;

  function automatic int midx(int b, int o);
    return (((b + o + m_rrb) % N) + N) % N;
  endfunction

  function automatic logic [DW-1:0] mread(int b, int o);
    if (we_i && midx(int'(wr_base_i), int'(wr_off_i)) == midx(b, o)) return wr_data_i;
    return m_mem[midx(b, o)];
  endfunction

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // inputs already set after a falling edge; compare, then clock
  task automatic tick(string req);
    #2;
    check(req, "rd0", rd0_data_o, mread(int'(rd0_base_i), int'(rd0_off_i)));
    check(req, "rd1", rd1_data_o, mread(int'(rd1_base_i), int'(rd1_off_i)));
    @(posedge clk_i);
    if (rst_ni) begin
      if (we_i) m_mem[midx(int'(wr_base_i), int'(wr_off_i))] = wr_data_i;
      if (rrb_clr_i) m_rrb = 0;
      else if (rotate_i) m_rrb = (m_rrb + N - 1) % N;
    end
    @(negedge clk_i);
  endtask

  task automatic set_rd(int b0, int o0, int b1, int o1);
    rd0_base_i = IW'(b0); rd0_off_i = OW'(o0);
    rd1_base_i = IW'(b1); rd1_off_i = OW'(o1);
  endtask

  task automatic set_wr(bit we, int b, int o, logic [DW-1:0] d);
    we_i = we; wr_base_i = IW'(b); wr_off_i = OW'(o); wr_data_i = d;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_mem[i] = '0;
    @(negedge clk_i);
    // R1: reads zero while held in reset
    set_rd(0, 0, 31, 0);
    tick("R1");
    set_rd(7, -3, 20, 5);
    tick("R1");
    rst_ni = 1'b1;
    set_rd(12, 0, 3, -1);
    tick("R1");

    // R2: write then read back next cycle
    set_wr(1, 3, 0, 32'hA5A5_0003);
    set_rd(9, 0, 9, 1);
    tick("R2");
    set_wr(0, 0, 0, '0);
    set_rd(3, 0, 2, 1);
    tick("R2");

    // R9: negative and positive offsets, independent ports
    set_wr(1, 5, -8, 32'h0000_BEEF);
    tick("R9");
    set_wr(1, 20, 7, 32'h1234_5678);
    tick("R9");
    set_wr(0, 0, 0, '0);
    set_rd(5, -8, 20, 7);
    tick("R9");
    set_rd(29, 0, 27, 0);
    tick("R9");

    // R6: same-cycle bypass on both ports
    set_wr(1, 10, 2, 32'hCAFE_F00D);
    set_rd(12, 0, 11, 1);
    tick("R6");
    set_wr(0, 0, 0, '0);
    tick("R6");

    // R3 / R5: loop writes element -1 with rotate each iteration
    for (int k = 0; k < 6; k++) begin
      set_wr(1, 16, -1, 32'h1000_0000 + DW'(k));
      rotate_i = 1'b1;
      set_rd(16, 0, 16, 1);
      tick("R5");
    end
    set_wr(0, 0, 0, '0);
    rotate_i = 1'b0;
    set_rd(16, 0, 16, 1);
    tick("R3");
    set_rd(16, 2, 16, 5);
    tick("R3");

    // R8: disabled write leaves contents alone
    set_wr(0, 16, 0, 32'hDEAD_DEAD);
    set_rd(16, 0, 16, 1);
    tick("R8");
    tick("R8");

    // R4: full wrap of the base, plus index wraparound
    rotate_i = 1'b1;
    set_wr(0, 0, 0, '0);
    for (int k = 0; k < N; k++) begin
      set_rd(16, 0, 31, 3);
      tick("R4");
    end
    rotate_i = 1'b0;
    set_rd(16, 0, 16, 2);
    tick("R4");
    set_wr(1, 31, 3, 32'h0BAD_0031);
    tick("R4");
    set_wr(0, 0, 0, '0);
    set_rd(2, 0, 31, 3);
    tick("R4");

    // R7: clear beats rotate, data retained; write uses old base
    rotate_i = 1'b1;
    tick("R7");
    tick("R7");
    rrb_clr_i = 1'b1;
    set_wr(1, 4, 0, 32'h7777_0004);
    tick("R7");
    rrb_clr_i = 1'b0;
    rotate_i = 1'b0;
    set_wr(0, 0, 0, '0);
    set_rd(2, 0, 16, 0);
    tick("R7");
    set_rd(4, 0, 4, -2);
    tick("R7");

    // R2: mixed traffic
    for (int k = 0; k < 400; k++) begin
      set_wr(($urandom % 3) != 0, int'($urandom % N), int'($urandom % 16) - 8, $urandom);
      rotate_i  = ($urandom % 4) == 0;
      rrb_clr_i = ($urandom % 50) == 0;
      set_rd(int'($urandom % N), int'($urandom % 16) - 8,
             int'($urandom % N), int'($urandom % 16) - 8);
      tick("R2");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule